// File: doc/BRIEF.md
# Manchester Packet Serialiser with Timing Preamble

The block turns a parallel payload word into one self-clocked frame on a single serial line. Each frame opens with two reference bits, which the far end times to learn the bit period. A body follows: the payload, then a CRC-8 computed over it. Every bit is Manchester coded, so a frame needs no separate clock wire. The line is forced idle for one guard bit after the frame, so that a receiver which has lost its place times out before the next frame begins.

The rate is set by a half-bit divider. This is the number of system clocks that each half of a bit occupies. The divider is raised to a floor of `MIN_HALF` clocks. With the default floor of 200 and a 50 MHz clock, the line changes state at most at 250 kHz, which gives a 125 kHz data rate. The controller is a four-state machine:

- `ST_IDLE`: the line is high and `busy` is low.
- `ST_REF`: the two reference bits are sent.
- `ST_BODY`: the payload and CRC bits are sent.
- `ST_GUARD`: the line is held high for one bit time while `busy` stays high.

Its transitions are:

- accept: `ST_IDLE` to `ST_REF`, when `send` is seen while idle.
- ref_done: `ST_REF` to `ST_BODY`, at the end of the second reference bit.
- body_done: `ST_BODY` to `ST_GUARD`, at the end of the last CRC bit.
- guard_done: `ST_GUARD` to `ST_IDLE`, at the end of the guard bit.

Top module: `mpkt_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `line_out` is 1 and `busy` is 0.
- R2: A frame begins with two reference bits of value 1, which appear on the line as high, low, high, low.
- R3: After the reference bits, the `PAYLOAD_W` (39) payload bits are sent, most significant bit first, as captured when `send` was accepted.
- R4: After the payload, the 8-bit CRC is sent, most significant bit first. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts from zero, and is fed with the payload most significant bit first.
- R5: A 1 is sent as a high half followed by a low half. A 0 is sent as a low half followed by a high half. The line therefore always changes at mid-bit.
- R6: Each half-bit lasts P system clocks, where P = max(`half_div`, `MIN_HALF`), sampled on the accept cycle.
- R7: After the 49 coded bits, the line is held high for one bit time (2P clocks) while `busy` stays 1.
- R8: `busy` rises on the clock edge that accepts `send` and stays high for exactly 100P cycles.
- R9: While `busy` is 1, `send`, `payload` and `half_div` have no effect on the frame in flight.
- R10: A `send` seen in the last guard cycle is ignored. If `send` is held, the next frame starts after exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send | input | 1 | Request to start a frame; honoured only while idle |
| payload | input | PAYLOAD_W | Payload word, captured on accept |
| half_div | input | DIV_W | Requested clocks per half-bit, before the floor is applied |
| line_out | output | 1 | Manchester coded serial line, idle high |
| busy | output | 1 | High from accept until the guard bit ends |

## Verification
End-of-frame and a new request can land on the same clock edge: the edge that closes the guard bit can also be the first edge at which a pending `send` is visible. The bench raises `send` during the final guard cycle and holds it there. It then checks that this edge leaves the block idle for one cycle with the line high. It also checks that the following edge starts a complete second frame carrying the new payload. A second collision is tested as well: a request with a changed payload and divider arrives in the middle of a frame. That frame is compared slot by slot against its original contents and timing.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REF   = 2'd1,
        ST_BODY  = 2'd2,
        ST_GUARD = 2'd3
    } tx_state_e;
endpackage

// File: rtl/mpkt_crc8.sv
module mpkt_crc8 #(
    parameter int          DATA_W = 39,
    parameter int          CRC_W  = 8,
    parameter logic [7:0]  POLY   = 8'h07,
    parameter logic [7:0]  INIT   = 8'h00
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = INIT[CRC_W-1:0];
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data_in[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ POLY[CRC_W-1:0];
        end
        crc_out = c;
    end
endmodule

// File: rtl/mpkt_slot_timer.sv
module mpkt_slot_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == period - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + DIV_W'(1);
    end

    // R6: counter never passes the half-bit length while running
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < period));
endmodule

// File: rtl/mpkt_tx.sv
module mpkt_tx #(
    parameter int PAYLOAD_W  = 39,
    parameter int CRC_W      = 8,
    parameter int REF_BITS   = 2,
    parameter int GUARD_BITS = 1,
    parameter int DIV_W      = 16,
    parameter int MIN_HALF   = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 send,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic [DIV_W-1:0]     half_div,
    output logic                 line_out,
    output logic                 busy
);
    import mpkt_pkg::*;

    localparam int BODY_W = PAYLOAD_W + CRC_W;
    localparam int CNT_W  = $clog2(BODY_W + 1);

    tx_state_e           state_q, state_d;
    logic                phase_q;
    logic [CNT_W-1:0]    bit_q;
    logic [BODY_W-1:0]   shreg_q;
    logic [DIV_W-1:0]    per_q;
    logic [DIV_W-1:0]    per_floor;
    logic [CRC_W-1:0]    crc_w;
    logic                tick;
    logic                accept;
    logic                last_half;

    assign per_floor = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
    assign accept    = (state_q == ST_IDLE) && send;
    assign last_half = tick && phase_q;

    mpkt_crc8 #(.DATA_W(PAYLOAD_W), .CRC_W(CRC_W)) u_crc (
        .data_in (payload),
        .crc_out (crc_w)
    );

    mpkt_slot_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q != ST_IDLE),
        .period (per_q),
        .tick   (tick)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (send) state_d = ST_REF;
            ST_REF:   if (last_half && bit_q == CNT_W'(REF_BITS - 1))   state_d = ST_BODY;
            ST_BODY:  if (last_half && bit_q == CNT_W'(BODY_W - 1))     state_d = ST_GUARD;
            ST_GUARD: if (last_half && bit_q == CNT_W'(GUARD_BITS - 1)) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            per_q   <= DIV_W'(MIN_HALF);
            phase_q <= 1'b0;
            bit_q   <= '0;
        end else if (accept) begin
            shreg_q <= {payload, crc_w};
            per_q   <= per_floor;
            phase_q <= 1'b0;
            bit_q   <= '0;
        end else if (tick) begin
            if (!phase_q) begin
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                if (state_q == ST_BODY) shreg_q <= shreg_q << 1;
                if (state_d != state_q) bit_q <= '0;
                else                    bit_q <= bit_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        line_out = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_REF:   line_out = ~phase_q;
            ST_BODY:  line_out = shreg_q[BODY_W-1] ^ phase_q;
            ST_GUARD: line_out = 1'b1;
        endcase
    end

    // R1: no frame in progress means an idle-high line
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R8: a frame only starts after a request
    a_r8_rise_needs_send: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(send));

    // R5: every coded bit changes level at mid-bit
    a_r5_mid_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_REF || state_q == ST_BODY) && tick && !phase_q)
            |=> (line_out != $past(line_out)));

    // R9: the latched period stays put through the frame
    a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(per_q));

    // R6: latched period respects the floor
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (per_q >= DIV_W'(MIN_HALF)));

    // R10: after the guard ends, the next edge restarts only on a pending request
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> (busy == $past(send)));
endmodule

// File: tb/sim_mpkt_tx.sv
module sim_mpkt_tx;
    localparam int PW    = 39;
    localparam int DW    = 16;
    localparam int FLOOR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          send = 1'b0;
    logic [PW-1:0] payload = '0;
    logic [DW-1:0] half_div = '0;
    logic          line_out;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mpkt_tx #(.MIN_HALF(FLOOR)) u0 (
        .clk(clk), .rst_n(rst_n), .send(send), .payload(payload),
        .half_div(half_div), .line_out(line_out), .busy(busy)
    );

    function automatic logic [7:0] ref_crc(input logic [PW-1:0] d);
        logic [7:0] c = 8'h00;
        logic fb;
        for (int i = PW - 1; i >= 0; i--) begin
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input int slot);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual %b expected %b", req, slot, act, exp);
        end
    endtask

    function automatic string slot_req(input int s);
        if (s < 4)  return "R2";
        if (s < 4 + 2*PW) return "R3";
        if (s < 98) return "R4";
        return "R7";
    endfunction

    // Drives one frame and checks all 100 half-bit slots at both ends.
    // poke_mid: change inputs mid-frame (R9); hold_end: raise send in last guard cycle (R10)
    task automatic run_frame(input logic [PW-1:0] pl, input int div,
                             input bit poke_mid, input bit hold_end);
        logic [48:0] bits;
        int p;
        logic e;
        p = (div < FLOOR) ? FLOOR : div;
        bits = {2'b11, pl, ref_crc(pl)};
        send = 1'b1; payload = pl; half_div = DW'(div);
        @(posedge clk); #1;
        send = 1'b0;
        for (int s = 0; s < 100; s++) begin
            if (s >= 98) e = 1'b1;
            else e = (s % 2 == 0) ? bits[48 - s/2] : ~bits[48 - s/2];
            chk(slot_req(s), line_out, e, s);
            chk("R8", busy, 1'b1, s);
            if (poke_mid && s == 20) begin
                send = 1'b1; payload = ~pl; half_div = DW'(p + 3);
            end
            if (poke_mid && s == 21) send = 1'b0;
            repeat (p - 1) @(posedge clk);
            #1;
            chk((s < 98) ? "R5" : "R7", line_out, e, s);
            chk("R6", busy, 1'b1, s);
            if (hold_end && s == 99) send = 1'b1;
            @(posedge clk); #1;
        end
        chk("R8", busy, 1'b0, 100);
        chk("R1", line_out, 1'b1, 100);
    endtask

    task automatic t_reset;
        #1;
        chk("R1", busy, 1'b0, -1);
        chk("R1", line_out, 1'b1, -1);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        chk("R1", busy, 1'b0, -1);
        chk("R1", line_out, 1'b1, -1);
    endtask

    task automatic t_patterns;
        run_frame(39'h55_5555_5555, 6, 1'b0, 1'b0);  // alternating, R3 R4
        repeat (3) @(posedge clk); #1;
        run_frame(39'h00_0000_0000, 5, 1'b0, 1'b0);  // all zero body
        repeat (2) @(posedge clk); #1;
        run_frame(39'h7F_FFFF_FFFF, 4, 1'b0, 1'b0);  // all ones, exact floor
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic t_clamp;
        run_frame(39'h12_3456_789A, 1, 1'b0, 1'b0);  // R6: div below floor
        repeat (2) @(posedge clk); #1;
        run_frame(39'h40_0000_0001, 0, 1'b0, 1'b0);  // R6: zero divider
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic t_busy_ignore;
        run_frame(39'h2A_C3F0_0F5B, 7, 1'b1, 1'b0);  // R9
        repeat (2) @(posedge clk); #1;
        chk("R9", busy, 1'b0, -2);
    endtask

    task automatic t_back_to_back;
        run_frame(39'h0F_0F0F_0F0F, 5, 1'b0, 1'b1);
        // R10: request seen at final guard edge left the block idle this cycle
        chk("R10", busy, 1'b0, -3);
        chk("R10", line_out, 1'b1, -3);
        run_frame(39'h61_2345_ABCD, 6, 1'b0, 1'b0);  // R10: starts on the next edge
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_clamp();
        t_busy_ignore();
        t_back_to_back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule